// File: doc/BRIEF.md
# Daisy-Chainable DAC Serial Interface

This block is the digital receive and reply logic in front of a single-channel 12-bit digital-to-analog converter. A host shifts 24-bit frames in on a serial clock and a data line, MSB first, and ends each frame with a rising edge on a latch strobe. That edge commits the received word. The upper eight bits select a target and the lower sixteen carry the payload. The block holds a data register whose upper twelve bits drive the converter code. It also holds a small control word with the output range and a chain-enable bit.

The serial reply line has two uses. In normal operation it is released (output enable low), except during the frame that follows a readback request. In that frame it returns eight padding bits and then the selected 16-bit register. With chaining enabled, the reply line stays driven and carries the word from the previous frame, so several devices can share one host port. An asynchronous clear input, with a selector, overrides the code presented to the converter. An active-low fault flag combines two externally sensed conditions.

The serial clock, latch, data and fault inputs are resynchronised to the system clock. The system clock must run at least four times faster than the serial clock.

Top module: `dac_serial_frontend`

## Requirements
- R1: Each frame is 24 bits. The data line is sampled on each rising serial-clock edge, first bit = bit 23. The rising latch edge commits the accumulated word, with the target in bits 23:16 and the payload in bits 15:0.
- R2: A committed word with target 0x01 stores the payload in the data register, and the code output becomes payload bits 15:4.
- R3: A committed word whose target is none of 0x01, 0x02, 0x55 changes neither the code output, nor the control word, nor the reply line.
- R4: Target 0x55 stores the control word: payload bits 2:0 select the range (0 to 3 voltage ranges, 4 to 7 current ranges) and payload bit 3 enables chaining.
- R5: Target 0x02 requests a readback, with payload bits 1:0 choosing the source: 0 data register, 1 control word as {12 zero bits, chain bit, range}, 2 status as {14 zero bits, over-temperature, open-circuit}, 3 all zero. During the following frame the output enable is high and the reply line carries 8 zero bits, then the 16 source bits MSB first, changing only after falling serial-clock edges.
- R6: At the latch edge that ends the frame after a readback request, the output enable goes low, unless that frame is itself a readback request.
- R7: With chaining enabled, the output enable stays high, and during each frame the reply line carries the full 24-bit word committed at the previous latch edge.
- R8: In a voltage range, while clear is high, the code output is 0x000 if the selector is low and 0x800 if it is high. This holds without any clock edge. When clear falls, the code output returns to the data register.
- R9: In a current range, clear forces the code output to 0x000 whatever the selector.
- R10: The fault flag is low when over-temperature is reported, or when open-circuit is reported while a current range is selected; otherwise it is high.
- R11: After reset the code output is 0x000, the output enable is low, chaining is off and range 0 is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sclk_i | input | 1 | Serial clock from host |
| sdin_i | input | 1 | Serial data from host |
| latch_i | input | 1 | Frame commit strobe, rising edge active |
| clear_i | input | 1 | Asynchronous clear, active high |
| clear_sel_i | input | 1 | Clear value select: low zero-scale, high mid-scale |
| open_ckt_i | input | 1 | Open-circuit condition reported by output stage |
| over_temp_i | input | 1 | Over-temperature condition |
| sdo_o | output | 1 | Serial reply data |
| sdo_oe_o | output | 1 | Reply output enable; low means high impedance |
| code_o | output | 12 | Code presented to the converter |
| fault_n_o | output | 1 | Fault flag, active low |

## Verification
The states that are hardest to reach from the ports are those where the reply line depends on more than one earlier frame. One is a readback request arriving in the frame right after another readback request. The other is the chained case, where the reply line must echo the word committed one latch earlier. The stimulus builds these states with bit-accurate frame sequences. It issues two readback requests back to back, then a no-operation frame, and checks the output enable after each latch. In chained mode it sends three distinct frames and compares each captured reply with the word sent one frame before. The clear override is also driven between clock edges, and during a data write, to show that it acts without a clock and that the data register still updates underneath it.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

   localparam int unsigned ADDR_BITS = 8;

   localparam logic [ADDR_BITS-1:0] ADR_DATA = 8'h01;
   localparam logic [ADDR_BITS-1:0] ADR_READ = 8'h02;
   localparam logic [ADDR_BITS-1:0] ADR_CTRL = 8'h55;

   typedef enum logic [1:0] {
      RB_DATA = 2'd0,
      RB_CTRL = 2'd1,
      RB_STAT = 2'd2,
      RB_NONE = 2'd3
   } rb_sel_e;

   typedef struct packed {
      logic       chain;
      logic [2:0] range;
   } ctrl_t;

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= async_i;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[g] <= '0;
         else        stg[g] <= stg[g-1];
      end
   end

   assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/dacif_frame.sv
module dacif_frame #(
   parameter int unsigned FRAME_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               latch_s,
   input  logic               sdin_s,
   output logic [FRAME_W-1:0] word_o,
   output logic               sclk_fall_o,
   output logic               commit_o
);

   logic               sclk_d;
   logic               latch_d;
   logic               sclk_rise;
   logic [FRAME_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         latch_d <= 1'b0;
      end else begin
         sclk_d  <= sclk_s;
         latch_d <= latch_s;
      end
   end

   assign sclk_rise   = sclk_s & ~sclk_d;
   assign sclk_fall_o = ~sclk_s & sclk_d;
   assign commit_o    = latch_s & ~latch_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         word_q <= '0;
      else if (sclk_rise) word_q <= {word_q[FRAME_W-2:0], sdin_s};
   end

   assign word_o = word_q;

   // R1
   shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> word_q[0] == $past(sdin_s));

endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
   import dacif_pkg::*;
#(
   parameter int unsigned FRAME_W = 24,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned CODE_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit_i,
   input  logic [FRAME_W-1:0] word_i,
   input  logic               open_s,
   input  logic               ot_s,
   input  logic               clear_i,
   input  logic               clear_sel_i,
   output logic [CODE_W-1:0]  code_o,
   output logic               fault_n_o,
   output logic               chain_next_o,
   output logic               rb_req_o,
   output logic [DATA_W-1:0]  rb_data_o
);

   localparam int unsigned CODE_LSB = DATA_W - CODE_W;
   localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] payload;
   logic [DATA_W-1:0] data_q;
   ctrl_t             ctrl_q;
   logic              cur_rng;
   logic              fault_n_q;
   logic [CODE_W-1:0] clear_val;

   assign addr    = word_i[FRAME_W-1 -: ADDR_W];
   assign payload = word_i[DATA_W-1:0];
   assign cur_rng = ctrl_q.range[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         ctrl_q <= '0;
      end else if (commit_i) begin
         if (addr == ADR_DATA) data_q <= payload;
         if (addr == ADR_CTRL) ctrl_q <= ctrl_t'(payload[3:0]);
      end
   end

   always_comb begin
      if (cur_rng || !clear_sel_i) clear_val = '0;
      else                         clear_val = MID_CODE;
   end

   assign code_o = clear_i ? clear_val : data_q[DATA_W-1:CODE_LSB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fault_n_q <= 1'b1;
      else        fault_n_q <= ~(ot_s | (open_s & cur_rng));
   end

   assign fault_n_o = fault_n_q;

   assign chain_next_o = (addr == ADR_CTRL) ? payload[3] : ctrl_q.chain;
   assign rb_req_o     = (addr == ADR_READ);

   always_comb begin
      case (rb_sel_e'(payload[1:0]))
         RB_DATA: rb_data_o = data_q;
         RB_CTRL: rb_data_o = {{(DATA_W-4){1'b0}}, ctrl_q};
         RB_STAT: rb_data_o = {{(DATA_W-2){1'b0}}, ot_s, open_s};
         default: rb_data_o = '0;
      endcase
   end

   // R2
   data_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i && addr == ADR_DATA |=> data_q == $past(payload));

   // R3
   unknown_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i && addr != ADR_DATA && addr != ADR_CTRL |=> $stable(data_q) && $stable(ctrl_q));

   // R8
   clear_volt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i && !cur_rng |-> code_o == (clear_sel_i ? MID_CODE : '0));

   // R9
   clear_curr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i && cur_rng |-> code_o == '0);

   // R10
   overtemp_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ot_s |=> !fault_n_q);

endmodule

// File: rtl/dacif_sdo.sv
module dacif_sdo #(
   parameter int unsigned FRAME_W = 24,
   parameter int unsigned DATA_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit_i,
   input  logic               sclk_fall_i,
   input  logic [FRAME_W-1:0] word_i,
   input  logic               chain_next_i,
   input  logic               rb_req_i,
   input  logic [DATA_W-1:0]  rb_data_i,
   output logic               sdo_o,
   output logic               sdo_oe_o
);

   localparam int unsigned PAD_W = FRAME_W - DATA_W;

   logic [FRAME_W-1:0] out_q;
   logic               oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         oe_q  <= 1'b0;
      end else if (commit_i) begin
         if (chain_next_i) begin
            out_q <= word_i;
            oe_q  <= 1'b1;
         end else if (rb_req_i) begin
            out_q <= {{PAD_W{1'b0}}, rb_data_i};
            oe_q  <= 1'b1;
         end else begin
            oe_q  <= 1'b0;
         end
      end else if (sclk_fall_i) begin
         out_q <= {out_q[FRAME_W-2:0], 1'b0};
      end
   end

   assign sdo_o    = oe_q & out_q[FRAME_W-1];
   assign sdo_oe_o = oe_q;

   // R5
   reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i && !sclk_fall_i |=> $stable(out_q));

   // R6
   reply_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i && !chain_next_i && !rb_req_i |=> !oe_q);

   // R7
   chain_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i && chain_next_i |=> oe_q && out_q == $past(word_i));

endmodule

// File: rtl/dac_serial_frontend.sv
module dac_serial_frontend #(
   parameter int unsigned FRAME_W     = 24,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CODE_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdin_i,
   input  logic              latch_i,
   input  logic              clear_i,
   input  logic              clear_sel_i,
   input  logic              open_ckt_i,
   input  logic              over_temp_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic [CODE_W-1:0] code_o,
   output logic              fault_n_o
);

   localparam int unsigned N_SYNC = 5;

   if (ADDR_W != dacif_pkg::ADDR_BITS) begin : g_bad_addr
      $error("ADDR_W must match the package target width");
   end
   if (FRAME_W != ADDR_W + DATA_W) begin : g_bad_frame
      $error("FRAME_W must equal ADDR_W + DATA_W");
   end
   if (CODE_W > DATA_W || DATA_W < 4) begin : g_bad_code
      $error("CODE_W must fit in DATA_W and DATA_W must be at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [N_SYNC-1:0]  raw_in;
   logic [N_SYNC-1:0]  syn;
   logic [FRAME_W-1:0] word;
   logic               sclk_fall;
   logic               commit;
   logic               chain_next;
   logic               rb_req;
   logic [DATA_W-1:0]  rb_data;

   assign raw_in = {over_temp_i, open_ckt_i, sdin_i, latch_i, sclk_i};

   dacif_sync #(.W(N_SYNC), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (raw_in),
      .sync_o  (syn)
   );

   dacif_frame #(.FRAME_W(FRAME_W)) frame_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_s      (syn[0]),
      .latch_s     (syn[1]),
      .sdin_s      (syn[2]),
      .word_o      (word),
      .sclk_fall_o (sclk_fall),
      .commit_o    (commit)
   );

   dacif_regs #(
      .FRAME_W (FRAME_W),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .CODE_W  (CODE_W)
   ) regs_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .commit_i     (commit),
      .word_i       (word),
      .open_s       (syn[3]),
      .ot_s         (syn[4]),
      .clear_i      (clear_i),
      .clear_sel_i  (clear_sel_i),
      .code_o       (code_o),
      .fault_n_o    (fault_n_o),
      .chain_next_o (chain_next),
      .rb_req_o     (rb_req),
      .rb_data_o    (rb_data)
   );

   dacif_sdo #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) sdo_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .commit_i     (commit),
      .sclk_fall_i  (sclk_fall),
      .word_i       (word),
      .chain_next_i (chain_next),
      .rb_req_i     (rb_req),
      .rb_data_i    (rb_data),
      .sdo_o        (sdo_o),
      .sdo_oe_o     (sdo_oe_o)
   );

   // R11
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe_o |-> !sdo_o);

endmodule

// File: tb/dac_serial_frontend_tb.sv
module dac_serial_frontend_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        sdin = 1'b0;
   logic        latch = 1'b0;
   logic        clr = 1'b0;
   logic        clr_sel = 1'b0;
   logic        open_ckt = 1'b0;
   logic        over_temp = 1'b0;
   logic        sdo;
   logic        sdo_oe;
   logic [11:0] code;
   logic        fault_n;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   dac_serial_frontend dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_i      (sclk),
      .sdin_i      (sdin),
      .latch_i     (latch),
      .clear_i     (clr),
      .clear_sel_i (clr_sel),
      .open_ckt_i  (open_ckt),
      .over_temp_i (over_temp),
      .sdo_o       (sdo),
      .sdo_oe_o    (sdo_oe),
      .code_o      (code),
      .fault_n_o   (fault_n)
   );

   // {range, clear_sel, clear, written code, expected code}
   localparam logic [28:0] VEC [8] = '{
      {3'd0, 1'b0, 1'b0, 12'hABC, 12'hABC},
      {3'd0, 1'b0, 1'b1, 12'h123, 12'h000},
      {3'd0, 1'b1, 1'b1, 12'h123, 12'h800},
      {3'd3, 1'b1, 1'b1, 12'hFFF, 12'h800},
      {3'd4, 1'b1, 1'b1, 12'h777, 12'h000},
      {3'd6, 1'b0, 1'b1, 12'h777, 12'h000},
      {3'd5, 1'b0, 1'b0, 12'hFFF, 12'hFFF},
      {3'd2, 1'b0, 1'b0, 12'h001, 12'h001}
   };

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [23:0] w, output logic [23:0] got);
      for (int i = 23; i >= 0; i--) begin
         sdin = w[i];
         wait_cyc(8);
         got[i] = sdo;
         sclk = 1'b1;
         wait_cyc(8);
         sclk = 1'b0;
      end
      wait_cyc(8);
      latch = 1'b1;
      wait_cyc(8);
      latch = 1'b0;
      wait_cyc(4);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [23:0] got;
      logic [2:0]  rng;
      logic        sel;
      logic        cl;
      logic [11:0] wc;
      logic [11:0] ex;

      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(3);

      // R11 reset state
      chk("R11 code", 32'(code), 32'h000);
      chk("R11 oe", 32'(sdo_oe), 32'h0);
      chk("R10 fault idle", 32'(fault_n), 32'h1);

      // R1 R2 R11 plain write in default mode keeps reply released
      xfer(24'h01_9C30, got);
      chk("R2 write", 32'(code), 32'h9C3);
      chk("R11 write mode oe", 32'(sdo_oe), 32'h0);

      // R3 unknown target ignored
      xfer(24'h7E_FFFF, got);
      chk("R3 code kept", 32'(code), 32'h9C3);
      chk("R3 oe kept", 32'(sdo_oe), 32'h0);

      // R2 R4 R8 R9 vector table
      for (int v = 0; v < 8; v++) begin
         {rng, sel, cl, wc, ex} = VEC[v];
         xfer({8'h55, 13'h0, rng}, got);
         xfer({8'h01, wc, 4'h0}, got);
         clr_sel = sel;
         clr = cl;
         #1;
         chk(!cl ? "R2 vec" : (rng[2] ? "R9 vec" : "R8 vec"), 32'(code), 32'(ex));
         clr = 1'b0;
         clr_sel = 1'b0;
         wait_cyc(2);
      end

      // R5 R6 readback of data register
      xfer(24'h01_ABCD, got);
      xfer(24'h02_0000, got);
      chk("R5 oe on", 32'(sdo_oe), 32'h1);
      xfer(24'h00_0000, got);
      chk("R5 data reply", 32'(got), 32'h00ABCD);
      chk("R6 oe off", 32'(sdo_oe), 32'h0);

      // R5 R10 status readback with over-temperature
      over_temp = 1'b1;
      wait_cyc(6);
      chk("R10 overtemp", 32'(fault_n), 32'h0);
      xfer(24'h02_0002, got);
      xfer(24'h00_0000, got);
      chk("R5 status reply", 32'(got), 32'h000002);
      over_temp = 1'b0;
      wait_cyc(6);

      // R4 R5 control readback
      xfer(24'h55_0005, got);
      xfer(24'h02_0001, got);
      xfer(24'h00_0000, got);
      chk("R4 ctrl reply", 32'(got), 32'h000005);

      // R10 open circuit in current range, then voltage range
      open_ckt = 1'b1;
      wait_cyc(6);
      chk("R10 open current", 32'(fault_n), 32'h0);
      xfer(24'h55_0000, got);
      wait_cyc(4);
      chk("R10 open voltage", 32'(fault_n), 32'h1);
      open_ckt = 1'b0;
      wait_cyc(6);

      // R6 back-to-back readback requests
      xfer(24'h02_0000, got);
      xfer(24'h02_0001, got);
      chk("R5 b2b first reply", 32'(got), 32'h00ABCD);
      chk("R6 b2b oe held", 32'(sdo_oe), 32'h1);
      xfer(24'h00_0000, got);
      chk("R5 b2b second reply", 32'(got), 32'h000000);
      chk("R6 b2b oe off", 32'(sdo_oe), 32'h0);

      // R7 chaining
      xfer(24'h55_0008, got);
      chk("R7 oe on", 32'(sdo_oe), 32'h1);
      xfer(24'h01_5A50, got);
      chk("R2 chain write", 32'(code), 32'h5A5);
      xfer(24'h7E_1234, got);
      chk("R7 echo 1", 32'(got), 32'h015A50);
      chk("R7 oe held", 32'(sdo_oe), 32'h1);
      xfer(24'h55_0000, got);
      chk("R7 echo 2", 32'(got), 32'h7E1234);
      chk("R6 chain off oe", 32'(sdo_oe), 32'h0);

      // R8 asynchronous clear and release
      #1;
      clr_sel = 1'b1;
      clr = 1'b1;
      #1;
      chk("R8 async mid", 32'(code), 32'h800);
      clr = 1'b0;
      #1;
      chk("R8 release", 32'(code), 32'h5A5);

      // R8 write under clear
      wait_cyc(1);
      clr_sel = 1'b0;
      clr = 1'b1;
      xfer(24'h01_0F00, got);
      chk("R8 held under clear", 32'(code), 32'h000);
      clr = 1'b0;
      #1;
      chk("R8 new data after release", 32'(code), 32'h0F0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule